// File: doc/BRIEF.md
# Dual-Page Streaming Histogram

This block counts how many times each data value appears on a valid-qualified input stream, all within one clock domain. The value of every accepted sample is used directly as a bin index. The addressed bin counter is then raised by one through a read-modify-write pipeline that sits in front of a RAM with separate read and write ports. There are two equal pages of bin counters. One page is active and takes the counts of the current sync period. The other page is idle and is open to a small memory-mapped read port and to a clear sequencer. A valid sample that carries the sync flag swaps the two pages.

The block has one software-facing step. When a sync arrives, the page that just finished counting becomes idle. Software reads its bins and can then clear it, while the stream keeps counting into the other page without interruption. Clears and reads must complete before the next sync swaps the pages again. The input never applies back-pressure: `in_ready` stays high, so a sample is taken on every cycle where `in_valid` is high, and the upstream side does not need to hold data.

Top module: `hist_pingpong`

## Requirements
- R1: After reset, `clearing` is low, `bus_rdval` is low, every bin of both pages reads zero, and samples accepted before the first sync are counted into the page that becomes readable at that first sync.
- R2: Each cycle with `in_valid` high adds one to the bin whose index is the unsigned value of `in_data` in the active page.
- R3: A cycle with `in_valid` low changes no bin, whatever `in_data` and `in_sync` hold.
- R4: Samples with the same bin on back-to-back valid cycles are each counted, with no count lost.
- R5: A bin counter that holds its maximum value 2^CNT_W-1, where CNT_W = ceil(log2(SAMPLES_PER_SYNC)), stays at that value and does not wrap.
- R6: A valid sample with `in_sync` high swaps the pages and is counted as the first sample of the new period. The page that was active becomes readable.
- R7: A `bus_rd` pulse makes `bus_rdval` go high exactly one cycle later, with `bus_rddata` holding the count of bin `bus_addr` in the page that is idle at the time of the read.
- R8: A one-cycle `clr_start` pulse zeroes every bin of the idle page. `clearing` rises on the next cycle and stays high for exactly 2^DATA_W cycles. The active page keeps counting during the clear.
- R9: `in_ready` is always high, so the stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stream, bus and RAM |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Always high; the block takes every sample |
| in_data | input | DATA_W | Sample value, used as the bin index |
| in_sync | input | 1 | With in_valid, starts a new period and swaps pages |
| clr_start | input | 1 | One-cycle pulse that starts zeroing the idle page |
| clearing | output | 1 | High while the clear sequence runs |
| bus_addr | input | DATA_W | Bin index to read from the idle page |
| bus_rd | input | 1 | Read strobe |
| bus_rdval | output | 1 | Read data valid, one cycle after bus_rd |
| bus_rddata | output | CNT_W | Bin count that was read |

## Verification
The bench builds the block with DATA_W = 3 and SAMPLES_PER_SYNC = 8. This gives eight bins per page with 3-bit counters, so a single read sweep covers every bin of a page, and a counter reaches saturation at 7 after only a few samples. Each period sends a different stream pattern: runs of repeated bins, interleaved invalid cycles that carry junk values and a set sync flag, and a rotating sweep. A clear is also run while counting continues. After each swap the whole idle page is read back and compared against counts that the bench works out from the stimulus.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef logic page_t;

  function automatic page_t other_page(page_t p);
    return ~p;
  endfunction
endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int AW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/hist_rmw.sv
module hist_rmw
  import hist_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  input  logic [AW-1:0]      s_bin,
  input  page_t              s_page,
  input  logic [1:0][DW-1:0] bank_q,
  output logic               wr_en,
  output page_t              wr_page,
  output logic [AW-1:0]      wr_bin,
  output logic [DW-1:0]      wr_data
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic          p1_vld;
  logic [AW-1:0] p1_bin;
  page_t         p1_pg;
  logic          fw_vld;
  logic [AW-1:0] fw_bin;
  page_t         fw_pg;
  logic [DW-1:0] fw_dat;
  logic [DW-1:0] base;
  logic [DW-1:0] nxt;

  // The write issued on the same edge as the next read is not yet visible
  // in the RAM output, so it is forwarded from a copy.
  always_comb begin
    if (fw_vld && fw_pg == p1_pg && fw_bin == p1_bin) base = fw_dat;
    else                                              base = bank_q[p1_pg];
    nxt = (base == CNT_MAX) ? base : base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_vld <= 1'b0;
      p1_bin <= '0;
      p1_pg  <= 1'b0;
      fw_vld <= 1'b0;
      fw_bin <= '0;
      fw_pg  <= 1'b0;
      fw_dat <= '0;
    end else begin
      p1_vld <= s_valid;
      p1_bin <= s_bin;
      p1_pg  <= s_page;
      fw_vld <= p1_vld;
      fw_bin <= p1_bin;
      fw_pg  <= p1_pg;
      fw_dat <= nxt;
    end
  end

  assign wr_en   = p1_vld;
  assign wr_page = p1_pg;
  assign wr_bin  = p1_bin;
  assign wr_data = nxt;
endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq
  import hist_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  page_t         idle_page,
  output logic          busy,
  output page_t         tgt_page,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tgt_page <= 1'b0;
      addr     <= '0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) busy <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      tgt_page <= idle_page;
      addr     <= '0;
    end
  end
endmodule

// File: rtl/hist_pingpong.sv
module hist_pingpong
  import hist_pkg::*;
#(
  parameter int DATA_W           = 8,
  parameter int SAMPLES_PER_SYNC = 1024,
  localparam int CNT_W           = $clog2(SAMPLES_PER_SYNC),
  localparam int NBINS           = 1 << DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sync,
  input  logic              clr_start,
  output logic              clearing,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic              bus_rdval,
  output logic [CNT_W-1:0]  bus_rddata
);
  page_t                  active_q;
  page_t                  cur_page;
  page_t                  idle_page;
  page_t                  bus_pg_q;
  page_t                  clr_pg;
  logic [DATA_W-1:0]      clr_addr;
  logic                   wr_en;
  page_t                  wr_page;
  logic [DATA_W-1:0]      wr_bin;
  logic [CNT_W-1:0]       wr_data;
  logic [1:0][CNT_W-1:0]  bank_q;

  assign in_ready  = 1'b1;
  assign cur_page  = active_q ^ (in_valid & in_sync);
  assign idle_page = other_page(cur_page);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      bus_pg_q  <= 1'b1;
      bus_rdval <= 1'b0;
    end else begin
      active_q  <= cur_page;
      bus_pg_q  <= idle_page;
      bus_rdval <= bus_rd;
    end
  end

  assign bus_rddata = bank_q[bus_pg_q];

  hist_clear_seq #(.AW(DATA_W)) u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (clr_start),
    .idle_page (idle_page),
    .busy      (clearing),
    .tgt_page  (clr_pg),
    .addr      (clr_addr)
  );

  hist_rmw #(.AW(DATA_W), .DW(CNT_W)) u_rmw (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_bin   (in_data),
    .s_page  (cur_page),
    .bank_q  (bank_q),
    .wr_en   (wr_en),
    .wr_page (wr_page),
    .wr_bin  (wr_bin),
    .wr_data (wr_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_page
    logic              clr_here;
    logic              strm_rd;
    logic              we;
    logic [DATA_W-1:0] waddr;
    logic [CNT_W-1:0]  wdata;
    logic [DATA_W-1:0] raddr;

    always_comb begin
      clr_here = clearing && (clr_pg == page_t'(g));
      strm_rd  = in_valid && (cur_page == page_t'(g));
      we       = clr_here || (wr_en && wr_page == page_t'(g));
      waddr    = clr_here ? clr_addr : wr_bin;
      wdata    = clr_here ? '0 : wr_data;
      raddr    = strm_rd ? in_data : bus_addr;
    end

    hist_bank #(.AW(DATA_W), .DW(CNT_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (bank_q[g])
    );
  end
endmodule

// File: rtl/hist_pingpong_chk.sv
module hist_pingpong_chk #(
  parameter int NBINS = 256
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic clr_start,
  input logic clearing,
  input logic bus_rd,
  input logic bus_rdval
);
  localparam int CW = $clog2(NBINS) + 2;

  logic [CW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        high_cnt <= '0;
    else if (clearing) high_cnt <= high_cnt + 1'b1;
    else               high_cnt <= '0;
  end

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R7
  rdval_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rdval);

  // R7
  rdval_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rdval);

  // R8
  clear_starts_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clearing) |-> $past(clr_start));

  // R8
  clear_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clearing && high_cnt < CW'(NBINS - 1)) |=> clearing);

  // R8
  clear_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> high_cnt == CW'(NBINS));
endmodule

bind hist_pingpong hist_pingpong_chk #(.NBINS(NBINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .clr_start (clr_start),
  .clearing  (clearing),
  .bus_rd    (bus_rd),
  .bus_rdval (bus_rdval)
);

// File: tb/test_hist_pingpong.sv
module test_hist_pingpong;
  localparam int PERIOD = 10;
  localparam int DW     = 3;
  localparam int SPS    = 8;
  localparam int CW     = $clog2(SPS);
  localparam int NB     = 1 << DW;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sync = 1'b0;
  logic          clr_start = 1'b0;
  logic          clearing;
  logic [DW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_rdval;
  logic [CW-1:0] bus_rddata;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt [2][NB];
  int act = 0;

  always #(PERIOD/2) clk = ~clk;

  hist_pingpong #(.DATA_W(DW), .SAMPLES_PER_SYNC(SPS)) i_hist_pingpong (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sync(in_sync), .clr_start(clr_start),
    .clearing(clearing), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdval(bus_rdval), .bus_rddata(bus_rddata)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic send(input logic v, input int d, input logic s);
    in_valid = v;
    in_data  = DW'(d);
    in_sync  = s;
    if (v) begin
      if (s) act = 1 - act;
      if (exp_cnt[act][d] < CMAX) exp_cnt[act][d]++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sync  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_page(input string req);
    for (int a = 0; a < NB; a++) begin
      bus_addr = DW'(a);
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check({req, " rdval"}, int'(bus_rdval), 1);
      check(req, int'(bus_rddata), exp_cnt[1-act][a]);
    end
  endtask

  task automatic do_clear(input bit stream);
    int hi;
    clr_start = 1'b1;
    @(negedge clk);
    clr_start = 1'b0;
    for (int b = 0; b < NB; b++) exp_cnt[1-act][b] = 0;
    hi = 0;
    for (int i = 0; i < 3 * NB && clearing; i++) begin
      hi++;
      if (stream) send(1'b1, (i * 3) % NB, 1'b0);
      else        @(negedge clk);
    end
    check("R8 clearing length", hi, NB);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) for (int b = 0; b < NB; b++) exp_cnt[p][b] = 0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R9: reset state
    check("R1 clearing after reset", int'(clearing), 0);
    check("R1 rdval after reset", int'(bus_rdval), 0);
    check("R9 ready", int'(in_ready), 1);
    read_page("R1 idle page zero");

    // R2 R4 R5 R3: bin b sent b+2 times back to back; bins 6,7 saturate.
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < b + 2; k++) send(1'b1, b, 1'b0);
      send(1'b0, 7 - b, 1'b1);  // R3: invalid with sync and junk value
    end
    send(1'b1, 2, 1'b1);        // R6: swap, sample counts in new page
    idle(2);
    read_page("R2/R4/R5 page after first swap");

    // R6 R3: rotating sweep with gaps
    for (int i = 0; i < 20; i++) begin
      send(1'b1, (i * 5) % NB, 1'b0);
      if (i % 3 == 0) send(1'b0, i % NB, 1'b0);
    end
    // R8: clear idle page while stream keeps counting
    do_clear(1'b1);
    idle(1);
    read_page("R8 cleared page");
    send(1'b1, 5, 1'b1);        // R6 swap back
    idle(2);
    read_page("R6/R8 counts kept during clear");

    // R4 R5: alternating pairs and long runs into the other page
    for (int i = 0; i < 12; i++) send(1'b1, (i / 2) % 2 ? 1 : 6, 1'b0);
    for (int i = 0; i < 10; i++) send(1'b1, 4, 1'b0);
    do_clear(1'b0);
    send(1'b1, 0, 1'b1);
    idle(2);
    read_page("R4/R5 run page");
    check("R9 ready end", int'(in_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule